// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the SPI target front end of a small register bank, such as the one in an eight-bit port expander. It watches a chip-select, a serial clock and a serial data input. It decodes a framed command and then performs reads and writes on an eleven-entry register file through a simple strobe port. The same port serves an I2C front end. Both SPI modes in which data is sampled on the rising clock edge are supported: clock idle low (mode 0) and clock idle high (mode 3). All three serial inputs pass through a synchroniser into the system clock domain, and edges are found there. The system clock must therefore run several times faster than the serial clock.

A frame opens when chip-select falls and closes when it rises. Each byte is shifted most significant bit first. The first byte is a command byte. Its upper five bits are a fixed prefix, the next two bits carry a board sub-address, and the lowest bit chooses read or write. The second byte loads the register pointer. Every byte after that is either written to the pointed register or shifted out from it on the serial output.

After each data byte the pointer advances and wraps from the last register to register zero. When the bank's hold bit is set, the pointer stays fixed instead. A command whose prefix is wrong, or whose sub-address fails the optional strap comparison, sends the frame to an ignore state.

The controller has six states:
- IDLE goes to OPCODE on a chip-select fall.
- OPCODE goes to ADDR when the command is accepted, or to IGNORE when it is refused.
- ADDR goes to WDATA or RDATA, as the command's direction bit selects.
- WDATA, RDATA and IGNORE hold until the frame ends.
- Chip-select high returns any state to IDLE.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset `so_oe`, `reg_wr` and `reg_rd` are low and the controller is idle.
- R2: A command byte `{0,1,0,0,0,s1,s0,d}` with d=0 (bit 0) followed by an address byte and a data byte produces exactly one single-cycle `reg_wr` pulse, with `reg_addr` equal to the address byte and `reg_wdata` equal to the data byte.
- R3: With d=1, the addressed register's value is shifted out on `so` MSB first, one bit per falling `sck` edge, valid at the next rising edge; each fetched byte gives one single-cycle `reg_rd` pulse.
- R4: With `hw_addr_en`=0, command bits 2:1 are ignored; with `hw_addr_en`=1 they must equal `strap[1:0]` for the command to be accepted.
- R5: With `seq_hold`=0, the pointer advances after every data byte and wraps from 0x0A to 0x00 within one frame, for both reads and writes.
- R6: `so_oe` is high only while read data is being shifted out; it is low during the command and address bytes and after chip-select rises.
- R7: With `seq_hold`=1, the pointer stays fixed, so repeated data bytes write or read the same register.
- R8: A refused command (prefix other than 01000, or strap mismatch) produces no `reg_wr` or `reg_rd` and keeps `so_oe` low until chip-select rises.
- R9: A data byte cut short by chip-select rising is discarded, and the next frame starts again at the command byte.
- R10: Frames in mode 3 (clock idle high, first edge falling) behave the same as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous) |
| si | input | 1 | Serial data in |
| strap | input | STRAP_W | Board sub-address straps |
| hw_addr_en | input | 1 | Enables strap comparison of command bits 2:1 |
| seq_hold | input | 1 | 1 freezes the register pointer |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (high = driven) |
| reg_addr | output | ADDR_W | Register pointer to the bank |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | DATA_W | Write data |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | DATA_W | Read data of `reg_addr`, combinational from the bank |

## Verification
The bench runs multi-byte frames that start at register 0x09 and 0x0A. A design that wraps at the wrong bound, or does not wrap, writes past the bank or returns the wrong second byte. It repeats bytes with the pointer frozen, so a design that still advances overwrites the neighbouring register. It sends command bytes whose strap bits mismatch, once with comparison off and once with it on. Mixing up the two cases either loses accepted writes or lets refused frames write or drive `so`. It cuts frames mid-byte, where a design that commits partial bytes corrupts the next register. It also runs clock-idle-high frames, where a design that treats the leading falling edge as data shifts every byte by one bit.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_IGNORE
    } spi_state_e;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rb_rx.sv
module spi_rb_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [DATA_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-2:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    assign byte_done = sample && (cnt_q == CNT_W'(DATA_W - 1));
    assign byte_val  = {sh_q, bit_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (sample) begin
            sh_q  <= {sh_q[DATA_W-3:0], bit_in};
            cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_rb_ptr.sv
module spi_rb_ptr #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              hold,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step && !hold) begin
            ptr <= (ptr >= LAST_ADDR) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/spi_rb_tx.sv
module spi_rb_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              active,
    output logic              so,
    output logic              so_oe
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else begin
            if (load) begin
                sh_q <= load_val;
            end else if (shift) begin
                sh_q <= {sh_q[DATA_W-2:0], 1'b0};
            end
            if (shift) begin
                so <= sh_q[DATA_W-1];
            end
            if (!active) begin
                so_oe <= 1'b0;
            end else if (shift) begin
                so_oe <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 8,
    parameter int                NUM_REGS    = 11,
    parameter int                STRAP_W     = 2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] OPC_BASE    = DATA_W'(8'h40)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               si,
    input  logic [STRAP_W-1:0] strap,
    input  logic               hw_addr_en,
    input  logic               seq_hold,
    output logic               so,
    output logic               so_oe,
    output logic [ADDR_W-1:0]  reg_addr,
    output logic               reg_wr,
    output logic [DATA_W-1:0]  reg_wdata,
    output logic               reg_rd,
    input  logic [DATA_W-1:0]  reg_rdata
);
    localparam int PFX_LO = STRAP_W + 1;

    spi_state_e state_q, state_d;

    logic [2:0]        sync_q;
    logic              cs_s, sck_s, si_s;
    logic              cs_prev, sck_prev;
    logic              sck_rise, sck_fall, cs_start;
    logic              byte_done;
    logic [DATA_W-1:0] byte_val;
    logic              opcode_ok;
    logic              rw_q, wr_pend_q, rd_pend_q;
    logic [DATA_W-1:0] wdata_q;
    logic              ptr_load, ptr_step;

    // input synchronisation and edge detection
    spi_rb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     (sync_q)
    );
    assign cs_s  = sync_q[2];
    assign sck_s = sync_q[1];
    assign si_s  = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign sck_rise = sck_s && !sck_prev;
    assign sck_fall = !sck_s && sck_prev;
    assign cs_start = cs_prev && !cs_s;

    spi_rb_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_s),
        .sample    (sck_rise && !cs_s),
        .bit_in    (si_s),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    assign opcode_ok = (byte_val[DATA_W-1:PFX_LO] == OPC_BASE[DATA_W-1:PFX_LO]) &&
                       (!hw_addr_en || (byte_val[STRAP_W:1] == strap));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_start)  state_d = ST_OPCODE;
            ST_OPCODE: if (byte_done) state_d = opcode_ok ? ST_ADDR : ST_IGNORE;
            ST_ADDR:   if (byte_done) state_d = rw_q ? ST_RDATA : ST_WDATA;
            ST_WDATA, ST_RDATA, ST_IGNORE: state_d = state_q;
            default:   state_d = ST_IDLE;
        endcase
        if (cs_s) state_d = ST_IDLE;
    end

    // byte-boundary actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q      <= 1'b0;
            wr_pend_q <= 1'b0;
            rd_pend_q <= 1'b0;
            wdata_q   <= '0;
        end else begin
            if (state_q == ST_OPCODE && byte_done) rw_q <= byte_val[0];
            wr_pend_q <= (state_q == ST_WDATA) && byte_done && !cs_s;
            rd_pend_q <= byte_done && !cs_s &&
                         ((state_q == ST_ADDR && rw_q) || state_q == ST_RDATA);
            if (state_q == ST_WDATA && byte_done) wdata_q <= byte_val;
        end
    end

    assign ptr_load = (state_q == ST_ADDR) && byte_done;
    assign ptr_step = wr_pend_q || ((state_q == ST_RDATA) && byte_done);

    spi_rb_ptr #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (byte_val[ADDR_W-1:0]),
        .step     (ptr_step),
        .hold     (seq_hold),
        .ptr      (reg_addr)
    );

    spi_rb_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_pend_q),
        .load_val (reg_rdata),
        .shift    ((state_q == ST_RDATA) && sck_fall),
        .active   (state_q == ST_RDATA),
        .so       (so),
        .so_oe    (so_oe)
    );

    // register-port outputs
    always_comb begin
        reg_wr    = wr_pend_q;
        reg_rd    = rd_pend_q;
        reg_wdata = wdata_q;
    end
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 11
) (
    input logic              clk,
    input logic              rst_n,
    input spi_state_e        state,
    input logic              so_oe,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              seq_hold
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

    assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    assert_no_wr_rd_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !seq_hold && reg_addr == LAST_ADDR) |=> (reg_addr == '0));

    assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> ($past(state) == ST_RDATA));

    assert_ptr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && seq_hold) |=> $stable(reg_addr));

    assert_ignore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!reg_wr && !reg_rd && !so_oe));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .so_oe    (so_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .seq_hold (seq_hold)
);

// File: tb/spi_regbank_slave_tb.sv
module spi_regbank_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic [1:0] strap = 2'b00;
    logic       hw_addr_en = 1'b0, seq_hold = 1'b0;
    logic       so, so_oe, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    logic [7:0] regs [11];
    int         wr_cnt, rd_cnt, oe_cnt;
    int         tests = 0, fails = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    spi_regbank_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .strap(strap), .hw_addr_en(hw_addr_en), .seq_hold(seq_hold),
        .so(so), .so_oe(so_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    // behavioural register bank
    assign reg_rdata = (reg_addr < 8'd11) ? regs[reg_addr] : 8'h00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 11; i++) regs[i] <= 8'h00;
            wr_cnt <= 0; rd_cnt <= 0; oe_cnt <= 0;
        end else begin
            if (reg_wr && reg_addr < 8'd11) regs[reg_addr] <= reg_wdata;
            if (reg_wr) wr_cnt <= wr_cnt + 1;
            if (reg_rd) rd_cnt <= rd_cnt + 1;
            if (so_oe)  oe_cnt <= oe_cnt + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic frame_begin(input logic cpol);
        sck = cpol; #40;
        cs_n = 1'b0; #40;
    endtask

    task automatic frame_end();
        #40; cs_n = 1'b1; #120;
    endtask

    task automatic xfer(input logic cpol, input logic [7:0] txb, output logic [7:0] rxb);
        for (int i = 7; i >= 0; i--) begin
            if (cpol) sck = 1'b0;
            si = txb[i];
            #40;
            rxb[i] = so;
            sck = 1'b1;
            #40;
            if (!cpol) sck = 1'b0;
        end
    endtask

    task automatic wr_frame(input logic cpol, input logic [7:0] op, input logic [7:0] a,
                            input logic [7:0] d [4], input int n);
        logic [7:0] dummy;
        frame_begin(cpol);
        xfer(cpol, op, dummy);
        xfer(cpol, a, dummy);
        for (int k = 0; k < n; k++) xfer(cpol, d[k], dummy);
        frame_end();
    endtask

    task automatic rd_frame(input logic cpol, input logic [7:0] op, input logic [7:0] a,
                            input int n, output logic [7:0] q [4], output int oe_after_op);
        logic [7:0] dummy;
        int base;
        base = oe_cnt;
        frame_begin(cpol);
        xfer(cpol, op, dummy);
        oe_after_op = oe_cnt - base;
        xfer(cpol, a, dummy);
        for (int k = 0; k < n; k++) xfer(cpol, 8'h00, q[k]);
        frame_end();
    endtask

    task automatic t_reset();
        check("R1 so_oe", so_oe, 0);
        check("R1 reg_wr", reg_wr, 0);
        check("R1 reg_rd", reg_rd, 0);
    endtask

    task automatic t_single_write();
        logic [7:0] d [4] = '{8'hA5, 8'h00, 8'h00, 8'h00};
        int w0 = wr_cnt;
        wr_frame(1'b0, 8'h40, 8'h03, d, 1);
        check("R2 reg3", regs[3], 8'hA5);
        check("R2 write count", wr_cnt - w0, 1);
    endtask

    task automatic t_seq_write_wrap();
        logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h00};
        wr_frame(1'b0, 8'h40, 8'h09, d, 3);
        check("R5 reg9", regs[9], 8'h11);
        check("R5 reg10", regs[10], 8'h22);
        check("R5 wrap reg0", regs[0], 8'h33);
    endtask

    task automatic t_seq_read_wrap();
        logic [7:0] q [4];
        int r0 = rd_cnt, base = oe_cnt, oe_op;
        rd_frame(1'b0, 8'h41, 8'h0A, 2, q, oe_op);
        check("R3 read reg10", q[0], 8'h22);
        check("R5 read wrap reg0", q[1], 8'h33);
        check("R3 read strobes", rd_cnt - r0, 3);
        check("R6 oe low in command byte", oe_op, 0);
        check("R6 oe seen in data", (oe_cnt - base) > 0, 1);
        check("R6 oe low after cs", so_oe, 0);
    endtask

    task automatic t_hold();
        logic [7:0] d [4] = '{8'h01, 8'h02, 8'h03, 8'h00};
        logic [7:0] q [4];
        int oe_op;
        seq_hold = 1'b1;
        wr_frame(1'b0, 8'h40, 8'h02, d, 3);
        check("R7 reg2 last byte", regs[2], 8'h03);
        check("R7 reg3 untouched", regs[3], 8'hA5);
        rd_frame(1'b0, 8'h41, 8'h02, 3, q, oe_op);
        check("R7 read 1", q[1], 8'h03);
        check("R7 read 2", q[2], 8'h03);
        seq_hold = 1'b0;
    endtask

    task automatic t_strap();
        logic [7:0] d [4] = '{8'h5A, 8'h00, 8'h00, 8'h00};
        int w0;
        hw_addr_en = 1'b0; strap = 2'b00;
        wr_frame(1'b0, 8'h46, 8'h04, d, 1);
        check("R4 straps ignored", regs[4], 8'h5A);
        hw_addr_en = 1'b1; strap = 2'b10;
        d[0] = 8'hC3;
        wr_frame(1'b0, 8'h44, 8'h04, d, 1);
        check("R4 strap match", regs[4], 8'hC3);
        w0 = wr_cnt;
        d[0] = 8'h99;
        wr_frame(1'b0, 8'h42, 8'h04, d, 1);
        check("R8 strap mismatch no write", regs[4], 8'hC3);
        check("R8 strap mismatch count", wr_cnt - w0, 0);
    endtask

    task automatic t_refused_read();
        logic [7:0] q [4];
        logic [7:0] d [4] = '{8'h77, 8'h00, 8'h00, 8'h00};
        int r0 = rd_cnt, base = oe_cnt, oe_op;
        rd_frame(1'b0, 8'h43, 8'h04, 2, q, oe_op);
        check("R8 refused read oe", oe_cnt - base, 0);
        check("R8 refused read strobes", rd_cnt - r0, 0);
        hw_addr_en = 1'b0;
        wr_frame(1'b0, 8'h50, 8'h04, d, 1);
        check("R8 bad prefix no write", regs[4], 8'hC3);
    endtask

    task automatic t_partial();
        logic [7:0] dummy;
        logic [7:0] d [4] = '{8'hEE, 8'h00, 8'h00, 8'h00};
        frame_begin(1'b0);
        xfer(1'b0, 8'h40, dummy);
        xfer(1'b0, 8'h06, dummy);
        xfer(1'b0, 8'h77, dummy);
        for (int i = 0; i < 4; i++) begin
            si = 1'b1; #40; sck = 1'b1; #40; sck = 1'b0;
        end
        frame_end();
        check("R9 full byte kept", regs[6], 8'h77);
        check("R9 partial byte dropped", regs[7], 8'h00);
        wr_frame(1'b0, 8'h40, 8'h07, d, 1);
        check("R9 next frame restarts", regs[7], 8'hEE);
    endtask

    task automatic t_mode3();
        logic [7:0] d [4] = '{8'h3C, 8'h00, 8'h00, 8'h00};
        logic [7:0] q [4];
        int oe_op;
        wr_frame(1'b1, 8'h40, 8'h01, d, 1);
        check("R10 mode3 write", regs[1], 8'h3C);
        rd_frame(1'b1, 8'h41, 8'h01, 1, q, oe_op);
        check("R10 mode3 read", q[0], 8'h3C);
        sck = 1'b0; #80;
    endtask

    initial begin
        #40 rst_n = 1'b1;
        #40;
        t_reset();
        t_single_write();
        t_seq_write_wrap();
        t_seq_read_wrap();
        t_hold();
        t_strap();
        t_refused_read();
        t_partial();
        t_mode3();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule